// File: doc/BRIEF.md
# Shared-Interrupt Host Glue for a Serial Port Bank

This block sits between a 16-bit host I/O bus and a bank of four or eight serial port controllers. It compares the whole I/O address against a base address set by a bank of switches, then picks one port from the low address bits, produces a one-hot chip select and passes the three-bit register offset on to the selected controller. Each port uses a window of eight bytes. The port windows are packed next to each other above the base address.

Each port's interrupt request only counts while that port's OUT2 modem-control output is active. The counted requests are ORed onto a single shared interrupt line. A status feature can be switched on. When it is on, offset 7 of every port window no longer reaches the controller. A read there returns a byte with one pending bit per port. A write there produces a fresh rising edge on the shared line, so an edge-triggered host controller sees the remaining work again. The written data is ignored.

Top module: `mpsi_glue`

## Requirements
- R1: A port chip select is driven only when every compared address bit (A15 down to A5 for four ports, A15 down to A6 for eight ports) equals the inverse of its switch input, where a switch input of 1 (ON) demands a 0 on that address bit.
- R2: On a base match, address bits above bit 2 in the port field select port n (counted from 0) at base + 8·n, cs_o has exactly that bit set, and reg_off_o equals addr_i[2:0].
- R3: With the status feature disabled, offset 7 of a port window asserts that port's chip select like any other offset, and stat_rd_o stays 0.
- R4: With the status feature enabled, a read at offset 7 of any port window asserts stat_rd_o, and no chip select is asserted at offset 7.
- R5: stat_o bit k is 1 exactly when port k has its request and its OUT2 input both at 1; bits for ports that are not built read 0.
- R6: A request from a port whose OUT2 input is 0 does not raise irq_o.
- R7: irq_o is 1 in the same cycle whenever any gated request is pending and no retrigger gap is running, and it is 0 when no gated request is pending.
- R8: A status write while stat_o is non-zero drives irq_o to 0 for RETRIG_CYC clock cycles, starting at the next rising edge. irq_o then returns to 1 if a request is still pending. The write leaves stat_o unchanged.
- R9: A status write while stat_o is zero has no effect: irq_o stays 0 and stat_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_on_i | input | 16-SEL_W | Base switches; 1 = ON = that address bit must be 0 |
| stat_en_i | input | 1 | Maps the status register over offset 7 of every port |
| addr_i | input | 16 | Host I/O address |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe, one cycle per access |
| irq_i | input | NUM_PORTS | Per-port interrupt request |
| out2_i | input | NUM_PORTS | Per-port OUT2 enable, 1 = active |
| cs_o | output | NUM_PORTS | One-hot port chip select |
| reg_off_o | output | 3 | Register offset within the port window |
| stat_rd_o | output | 1 | Read hits the status register |
| stat_o | output | 8 | Per-port pending bits |
| irq_o | output | 1 | Shared interrupt line |

## Verification
The decode outputs, stat_o and irq_o are combinational functions of the inputs. The bench therefore drives each stimulus at a falling edge and samples one time unit later, before the next rising edge. The only register is the retrigger gap counter. The counter loads at the rising edge that samples a status write, so irq_o is expected low at the next RETRIG_CYC falling-edge samples and high again at the one after. The bench checks exactly those samples, and it releases wr_i right after that loading edge.

// File: rtl/mpsi_pkg.sv
package mpsi_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned REG_W  = 3;
  localparam int unsigned STAT_W = 8;
  localparam logic [REG_W-1:0] STAT_OFF = 3'd7;
endpackage

// File: rtl/mpsi_addr_dec.sv
module mpsi_addr_dec
  import mpsi_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned SEL_W = $clog2(NUM_PORTS) + REG_W,
  localparam int unsigned CMP_W = ADDR_W - SEL_W
) (
  input  logic [CMP_W-1:0]     sw_on_i,
  input  logic                 stat_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  output logic [NUM_PORTS-1:0] cs_o,
  output logic [REG_W-1:0]     reg_off_o,
  output logic                 stat_rd_o,
  output logic                 stat_wr_o
);
  localparam int unsigned IDX_W = SEL_W - REG_W;

  logic             base_hit;
  logic             stat_slot;
  logic [IDX_W-1:0] port_idx;

  // ON switch => address bit must be 0
  assign base_hit  = (addr_i[ADDR_W-1:SEL_W] == ~sw_on_i);
  assign port_idx  = addr_i[SEL_W-1:REG_W];
  assign reg_off_o = addr_i[REG_W-1:0];
  assign stat_slot = base_hit && stat_en_i && (reg_off_o == STAT_OFF);
  assign stat_rd_o = stat_slot && rd_i;
  assign stat_wr_o = stat_slot && wr_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_cs
    assign cs_o[p] = base_hit && !stat_slot && (port_idx == IDX_W'(p));
  end
endmodule

// File: rtl/mpsi_irq_merge.sv
module mpsi_irq_merge
  import mpsi_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned RETRIG_CYC = 2,
  localparam int unsigned CNT_W = $clog2(RETRIG_CYC + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] irq_i,
  input  logic [NUM_PORTS-1:0] out2_i,
  input  logic                 retrig_i,
  output logic [STAT_W-1:0]    stat_o,
  output logic                 irq_o
);
  logic [CNT_W-1:0] gap_q;
  logic             any_pend;

  for (genvar k = 0; k < STAT_W; k++) begin : g_stat
    if (k < NUM_PORTS) begin : g_live
      assign stat_o[k] = irq_i[k] && out2_i[k];
    end else begin : g_absent
      assign stat_o[k] = 1'b0;
    end
  end

  assign any_pend = |stat_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
    end else if (retrig_i && any_pend) begin
      gap_q <= CNT_W'(RETRIG_CYC);
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign irq_o = any_pend && (gap_q == '0);

  AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_pend |-> !irq_o); // R7
  AST_RETRIG_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retrig_i && any_pend) |=> !irq_o); // R8
  AST_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(gap_q) == CNT_W'(1) && !$past(retrig_i) && any_pend) |-> irq_o); // R8
endmodule

// File: rtl/mpsi_glue.sv
module mpsi_glue
  import mpsi_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned RETRIG_CYC = 2,
  localparam int unsigned SEL_W = $clog2(NUM_PORTS) + REG_W,
  localparam int unsigned CMP_W = ADDR_W - SEL_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CMP_W-1:0]     sw_on_i,
  input  logic                 stat_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [NUM_PORTS-1:0] irq_i,
  input  logic [NUM_PORTS-1:0] out2_i,
  output logic [NUM_PORTS-1:0] cs_o,
  output logic [REG_W-1:0]     reg_off_o,
  output logic                 stat_rd_o,
  output logic [STAT_W-1:0]    stat_o,
  output logic                 irq_o
);
  logic stat_wr;

  mpsi_addr_dec #(.NUM_PORTS(NUM_PORTS)) u_dec (
    .sw_on_i   (sw_on_i),
    .stat_en_i (stat_en_i),
    .addr_i    (addr_i),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .cs_o      (cs_o),
    .reg_off_o (reg_off_o),
    .stat_rd_o (stat_rd_o),
    .stat_wr_o (stat_wr)
  );

  mpsi_irq_merge #(.NUM_PORTS(NUM_PORTS), .RETRIG_CYC(RETRIG_CYC)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_i    (irq_i),
    .out2_i   (out2_i),
    .retrig_i (stat_wr),
    .stat_o   (stat_o),
    .irq_o    (irq_o)
  );

  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o)); // R2
  AST_STAT_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_o |-> (cs_o == '0)); // R4
  AST_CS_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o != '0) |-> (reg_off_o == addr_i[REG_W-1:0])); // R2
  AST_GATED_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_i & out2_i) == '0) |-> !irq_o); // R6
endmodule

// File: tb/tb_mpsi_glue.sv
module tb_mpsi_glue;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NP = 4;
  localparam int unsigned RC = 2;
  localparam int unsigned SW_W = 11;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [SW_W-1:0] sw_on = '0;
  logic          stat_en = 1'b0;
  logic [15:0]   addr = '0;
  logic          rd = 1'b0, wr = 1'b0;
  logic [NP-1:0] irq = '0, out2 = '0;
  logic [NP-1:0] cs;
  logic [2:0]    reg_off;
  logic          stat_rd;
  logic [7:0]    stat;
  logic          irq_line;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpsi_glue #(.NUM_PORTS(NP), .RETRIG_CYC(RC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sw_on_i(sw_on), .stat_en_i(stat_en),
    .addr_i(addr), .rd_i(rd), .wr_i(wr), .irq_i(irq), .out2_i(out2),
    .cs_o(cs), .reg_off_o(reg_off), .stat_rd_o(stat_rd), .stat_o(stat),
    .irq_o(irq_line)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_base(logic [15:0] base);
    sw_on = ~base[15:5];
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    step();
    chk("R7", "irq after reset", int'(irq_line), 0);
    chk("R5", "stat after reset", int'(stat), 0);
  endtask

  task automatic t_decode();
    set_base(16'h0300); stat_en = 1'b0; rd = 1'b1;
    for (int p = 0; p < NP; p++) begin
      addr = 16'h0300 + 16'(8*p) + 16'd3; #1;
      chk("R2", "cs port", int'(cs), 1 << p);
      chk("R2", "reg offset", int'(reg_off), 3);
    end
    set_base(16'h5AC0);
    addr = 16'h5AC0 + 16'd24 + 16'd5; #1;
    chk("R2", "cs base 5AC0 port3", int'(cs), 8);
    chk("R2", "offset base 5AC0", int'(reg_off), 5);
    addr = 16'h5AE0; #1;
    chk("R1", "miss above window", int'(cs), 0);
    addr = 16'hDAC0; #1;
    chk("R1", "miss on A15", int'(cs), 0);
    addr = 16'h5A80; #1;
    chk("R1", "miss on A6", int'(cs), 0);
    rd = 1'b0;
  endtask

  task automatic t_stat_map();
    set_base(16'h0300); rd = 1'b1;
    stat_en = 1'b0; addr = 16'h0300 + 16'd15; #1;
    chk("R3", "cs at offset7 disabled", int'(cs), 2);
    chk("R3", "stat_rd disabled", int'(stat_rd), 0);
    stat_en = 1'b1;
    for (int p = 0; p < NP; p++) begin
      addr = 16'h0300 + 16'(8*p) + 16'd7; #1;
      chk("R4", "stat_rd enabled", int'(stat_rd), 1);
      chk("R4", "no cs at offset7", int'(cs), 0);
    end
    addr = 16'h0306; #1;
    chk("R4", "offset6 still to port", int'(cs), 1);
    rd = 1'b0;
  endtask

  task automatic t_status();
    irq = 4'b1011; out2 = 4'b0011; step();
    chk("R5", "status gated", int'(stat), 8'h03);
    chk("R7", "irq pending", int'(irq_line), 1);
    irq = 4'b1000; out2 = 4'b0111; step();
    chk("R6", "ungated request silent", int'(irq_line), 0);
    chk("R5", "status ungated zero", int'(stat), 0);
    irq = 4'b1111; out2 = 4'b1111; step();
    chk("R5", "all pending, upper bits 0", int'(stat), 8'h0F);
    irq = 4'b0000; step();
    chk("R7", "irq drops when none", int'(irq_line), 0);
  endtask

  task automatic t_retrig();
    stat_en = 1'b1; set_base(16'h0300);
    irq = 4'b0100; out2 = 4'b1111; addr = 16'h0317;
    step();
    chk("R7", "irq before retrig", int'(irq_line), 1);
    wr = 1'b1;
    @(posedge clk); #1; wr = 1'b0;
    for (int c = 0; c < RC; c++) begin
      step();
      chk("R8", "irq low in gap", int'(irq_line), 0);
      chk("R8", "status kept", int'(stat), 8'h04);
    end
    step();
    chk("R8", "irq rearmed", int'(irq_line), 1);
    irq = 4'b0000; step();
    wr = 1'b1;
    @(posedge clk); #1; wr = 1'b0;
    step();
    chk("R9", "zero status write irq", int'(irq_line), 0);
    chk("R9", "zero status write stat", int'(stat), 0);
    irq = 4'b0001; #1;
    chk("R9", "new request immediate", int'(irq_line), 1);
    irq = 4'b0000;
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_decode();
    t_stat_map();
    t_status();
    t_retrig();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule